// File: doc/BRIEF.md
# Filtered Event Performance Counter Slot

This block is one performance-counter slot for an I/O address translation unit. Software selects one event by writing an 8-bit event code. It can also narrow the count to a subset of transactions with three match filters: one on the device identifier, one on the process address space identifier (PASID) and one on the domain identifier. Each filter has a compare value, a don't-care mask and its own enable flag. In every clock cycle where the strobe for the selected event is high and every enabled filter agrees with the transaction's identifiers, the 48-bit count goes up by one.

The slot is used only for counting, with no sampling and no overflow interrupt. Software enables the slot by writing a nonzero code, then writes zero to the count, lets events accumulate and reads the count back. An event code of zero turns the slot off, which models a power-gated counter. While the slot is off, writes to the count are dropped and reads of the count return zero. Software must therefore read the count before it turns the slot off.

Registers are written through a single-cycle address, write-enable and 64-bit data port. A separate combinational read port returns the register selected by its own address.

Top module: `evcnt_slot`

## Requirements
- R1: After reset, all five registers (source 0, device match 1, PASID match 2, domain match 3, count 4) read as zero, and the slot is disabled.
- R2: The source register keeps data bits 7:0 and reads back only those bits. Code c in the range 1 to 24 counts the strobe `evStrobe[c]`. Code 0 disables the slot. A nonzero code above 24 keeps the slot powered but matches no strobe, so it never counts.
- R3: In each match register, the compare value sits at bit 0 upward, the enable flag at bit 31 and the mask at bit 32 upward. The device and domain filters use 16-bit fields and the PASID filter uses 20-bit fields. Readback shows exactly these fields, and every other bit reads zero.
- R4: The count rises by exactly one in each cycle where the slot is enabled, the selected strobe is high and all filters pass. The new value is readable in the cycle after that clock edge.
- R5: A filter whose enable flag is clear passes every transaction.
- R6: An enabled filter passes when each transaction ID bit whose mask bit is 0 equals the stored value bit. A mask bit of 1 makes that ID bit don't-care.
- R7: Each of the three filters applies on its own, and a single enabled filter that fails blocks the count.
- R8: While the source code is zero, writes to the count are ignored and count reads return zero. The count held before the slot was disabled reads back again once the slot is re-enabled.
- R9: A count write while the slot is enabled loads data bits 47:0. Bits 63:48 of a count read are always zero.
- R10: When a count write and a qualifying event fall in the same cycle, the written value is kept and that increment is lost.
- R11: The count wraps from 2^48-1 to 0 without any flag.
- R12: A source write takes effect at its clock edge. The event in the cycle of the write is judged against the previous code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Write register select (0 source, 1 device, 2 PASID, 3 domain, 4 count) |
| regWrData | input | 64 | Write data |
| regRdAddr | input | 3 | Read register select, same encoding |
| regRdData | output | 64 | Combinational read data |
| evStrobe | input | 25 | Event strobes indexed by event code (bit 0 unused) |
| txnDevId | input | 16 | Device ID of the current transaction |
| txnPasid | input | 20 | PASID of the current transaction |
| txnDomId | input | 16 | Domain ID of the current transaction |

## Verification
A software write to the count can land in the same cycle as a qualifying event, and a write to the source register can land in the same cycle as an event strobe. The bench drives the write and the strobe on one falling edge. For the count write it checks that the read shows the written value with no extra increment. For the source write it raises the strobes for both the old and the new code, then checks that only the old code's event was counted.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int SRC_W      = 8;
  localparam int REG_W      = 64;
  localparam int ADDR_W     = 3;
  localparam int EN_BIT     = 31;
  localparam int MASK_LSB   = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRC  = 3'd0,
    REG_DEVM = 3'd1,
    REG_PASM = 3'd2,
    REG_DOMM = 3'd3,
    REG_CNT  = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic gated;
    logic load;
    logic inc;
  } cntCmd_t;
endpackage

// File: rtl/evcnt_idfilter.sv
module evcnt_idfilter #(
  parameter int ID_W = 16
) (
  input  logic [ID_W-1:0] idIn,
  input  logic [ID_W-1:0] valQ,
  input  logic [ID_W-1:0] maskQ,
  input  logic            enQ,
  output logic            pass
);
  logic [ID_W-1:0] diff;

  // bits that differ and are not masked out as don't-care
  assign diff = (idIn ^ valQ) & ~maskQ;
  assign pass = !enQ || (diff == '0);
endmodule

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
#(
  parameter int NUM_EVENTS = 25,
  parameter int DEV_W      = 16,
  parameter int PAS_W      = 20,
  parameter int DOM_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [REG_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [NUM_EVENTS-1:0] evStrobe,
  input  logic [DEV_W-1:0]      devId,
  input  logic [PAS_W-1:0]      pasid,
  input  logic [DOM_W-1:0]      domId,
  output cntCmd_t               cmd,
  output logic [REG_W-1:0]      cfgRdData
);
  localparam int PAD_W = 1 << SRC_W;

  logic [SRC_W-1:0] srcQ;
  logic [DEV_W-1:0] devValQ, devMaskQ;
  logic [PAS_W-1:0] pasValQ, pasMaskQ;
  logic [DOM_W-1:0] domValQ, domMaskQ;
  logic             devEnQ, pasEnQ, domEnQ;
  logic             devPass, pasPass, domPass;
  logic [PAD_W-1:0] evPad;
  logic             evHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ     <= '0;
      devValQ  <= '0; devMaskQ <= '0; devEnQ <= 1'b0;
      pasValQ  <= '0; pasMaskQ <= '0; pasEnQ <= 1'b0;
      domValQ  <= '0; domMaskQ <= '0; domEnQ <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        REG_SRC:  srcQ <= wrData[SRC_W-1:0];
        REG_DEVM: begin
          devValQ  <= wrData[DEV_W-1:0];
          devEnQ   <= wrData[EN_BIT];
          devMaskQ <= wrData[MASK_LSB +: DEV_W];
        end
        REG_PASM: begin
          pasValQ  <= wrData[PAS_W-1:0];
          pasEnQ   <= wrData[EN_BIT];
          pasMaskQ <= wrData[MASK_LSB +: PAS_W];
        end
        REG_DOMM: begin
          domValQ  <= wrData[DOM_W-1:0];
          domEnQ   <= wrData[EN_BIT];
          domMaskQ <= wrData[MASK_LSB +: DOM_W];
        end
        default: ;
      endcase
    end
  end

  evcnt_idfilter #(.ID_W(DEV_W)) uDevFilt (
    .idIn(devId), .valQ(devValQ), .maskQ(devMaskQ), .enQ(devEnQ), .pass(devPass));
  evcnt_idfilter #(.ID_W(PAS_W)) uPasFilt (
    .idIn(pasid), .valQ(pasValQ), .maskQ(pasMaskQ), .enQ(pasEnQ), .pass(pasPass));
  evcnt_idfilter #(.ID_W(DOM_W)) uDomFilt (
    .idIn(domId), .valQ(domValQ), .maskQ(domMaskQ), .enQ(domEnQ), .pass(domPass));

  // codes beyond the strobe array select a constant zero
  assign evPad = PAD_W'(evStrobe);
  assign evHit = evPad[srcQ];

  assign cmd.gated = (srcQ == '0);
  assign cmd.load  = wrEn && (wrAddr == REG_CNT) && !cmd.gated;
  assign cmd.inc   = !cmd.gated && evHit && devPass && pasPass && domPass;

  always_comb begin
    cfgRdData = '0;
    case (rdAddr)
      REG_SRC:  cfgRdData[SRC_W-1:0] = srcQ;
      REG_DEVM: begin
        cfgRdData[DEV_W-1:0]          = devValQ;
        cfgRdData[EN_BIT]             = devEnQ;
        cfgRdData[MASK_LSB +: DEV_W]  = devMaskQ;
      end
      REG_PASM: begin
        cfgRdData[PAS_W-1:0]          = pasValQ;
        cfgRdData[EN_BIT]             = pasEnQ;
        cfgRdData[MASK_LSB +: PAS_W]  = pasMaskQ;
      end
      REG_DOMM: begin
        cfgRdData[DOM_W-1:0]          = domValQ;
        cfgRdData[EN_BIT]             = domEnQ;
        cfgRdData[MASK_LSB +: DOM_W]  = domMaskQ;
      end
      default: ;
    endcase
  end

  // R5: a switched-off filter never blocks
  a_r5_dev_off_pass: assert property (@(posedge clk) disable iff (!rstN)
    !devEnQ |-> devPass);
  a_r5_pas_off_pass: assert property (@(posedge clk) disable iff (!rstN)
    !pasEnQ |-> pasPass);
  // R7: an increment needs every filter to agree
  a_r7_all_pass: assert property (@(posedge clk) disable iff (!rstN)
    cmd.inc |-> (devPass && pasPass && domPass));
  // R12: a source write is visible from the next cycle
  a_r12_src_next: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == REG_SRC) |=> srcQ == $past(wrData[SRC_W-1:0]));
endmodule

// File: rtl/evcnt_datapath.sv
module evcnt_datapath
  import evcnt_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [REG_W-1:0] loadData,
  output logic [REG_W-1:0] cntRead
);
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN)
      countQ <= '0;
    else if (cmd.load)
      countQ <= loadData[CNT_W-1:0];
    else if (cmd.inc)
      countQ <= countQ + 1'b1;
  end

  assign cntRead = cmd.gated ? '0 : REG_W'(countQ);

  // R8: a gated slot holds its count
  a_r8_gated_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmd.gated |=> $stable(countQ));
  // R4 / R11: single step, modulo the counter width
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.inc && !cmd.load) |=> countQ == $past(countQ) + 1'b1);
  // R10: a write beats a simultaneous increment
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> countQ == $past(loadData[CNT_W-1:0]));
  // R9: nothing above the counter width is ever returned
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    cntRead[REG_W-1:CNT_W] == '0);
endmodule

// File: rtl/evcnt_slot.sv
module evcnt_slot
  import evcnt_pkg::*;
#(
  parameter int NUM_EVENTS = 25,
  parameter int CNT_W      = 48,
  parameter int DEV_W      = 16,
  parameter int PAS_W      = 20,
  parameter int DOM_W      = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [2:0]            regWrAddr,
  input  logic [63:0]           regWrData,
  input  logic [2:0]            regRdAddr,
  output logic [63:0]           regRdData,
  input  logic [NUM_EVENTS-1:0] evStrobe,
  input  logic [DEV_W-1:0]      txnDevId,
  input  logic [PAS_W-1:0]      txnPasid,
  input  logic [DOM_W-1:0]      txnDomId
);
  cntCmd_t          cmd;
  logic [REG_W-1:0] cfgRdData;
  logic [REG_W-1:0] cntRead;

  evcnt_ctrl #(
    .NUM_EVENTS(NUM_EVENTS), .DEV_W(DEV_W), .PAS_W(PAS_W), .DOM_W(DOM_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEn(regWrEn), .wrAddr(regWrAddr), .wrData(regWrData),
    .rdAddr(regRdAddr), .evStrobe(evStrobe),
    .devId(txnDevId), .pasid(txnPasid), .domId(txnDomId),
    .cmd(cmd), .cfgRdData(cfgRdData)
  );

  evcnt_datapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .loadData(regWrData), .cntRead(cntRead)
  );

  assign regRdData = (regRdAddr == REG_CNT) ? cntRead : cfgRdData;
endmodule

// File: tb/evcnt_slot_test.sv
module evcnt_slot_test;
  localparam int NEV = 25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrAddr = '0;
  logic [63:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [63:0] regRdData;
  logic [NEV-1:0] evStrobe = '0;
  logic [15:0] txnDevId = '0;
  logic [19:0] txnPasid = '0;
  logic [15:0] txnDomId = '0;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  evcnt_slot uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .evStrobe(evStrobe), .txnDevId(txnDevId), .txnPasid(txnPasid),
    .txnDomId(txnDomId)
  );

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [63:0] exp, input string tag);
    regRdAddr = a;
    #1;
    nRun++;
    if (regRdData !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, regRdData, exp);
    end
  endtask

  task automatic pulse(input int code, input int n);
    for (int i = 0; i < n; i++) begin
      evStrobe = '0;
      evStrobe[code] = 1'b1;
      @(negedge clk);
    end
    evStrobe = '0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 5; a++) rdChk(3'(a), 64'd0, "R1 reset read");
  endtask

  task automatic t_layout();
    wr(3'd1, '1);
    rdChk(3'd1, 64'h0000_FFFF_8000_FFFF, "R3 device layout");
    wr(3'd2, '1);
    rdChk(3'd2, 64'h000F_FFFF_800F_FFFF, "R3 pasid layout");
    wr(3'd3, 64'h0000_1234_0000_5678);
    rdChk(3'd3, 64'h0000_1234_0000_5678, "R3 domain layout");
    wr(3'd0, 64'h1FF);
    rdChk(3'd0, 64'hFF, "R2 source width");
    wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0); wr(3'd0, 0);
  endtask

  task automatic t_gate();
    wr(3'd4, 64'd99);
    rdChk(3'd4, 64'd0, "R8 gated read");
    wr(3'd0, 64'd5);
    rdChk(3'd4, 64'd0, "R8 gated write ignored");
    wr(3'd4, 64'd7);
    rdChk(3'd4, 64'd7, "R8 enabled load");
    wr(3'd0, 64'd0);
    wr(3'd4, 64'd123);
    pulse(5, 2);
    rdChk(3'd4, 64'd0, "R8 gated read zero");
    wr(3'd0, 64'd5);
    rdChk(3'd4, 64'd7, "R8 count retained");
  endtask

  task automatic t_count();
    wr(3'd0, 64'd3);
    wr(3'd4, 64'd0);
    pulse(3, 4);
    rdChk(3'd4, 64'd4, "R4 four events");
    pulse(4, 2);
    rdChk(3'd4, 64'd4, "R2 other code ignored");
    pulse(24, 1);
    wr(3'd0, 64'd24);
    pulse(24, 1);
    rdChk(3'd4, 64'd5, "R2 highest code");
    wr(3'd0, 64'h30);
    for (int i = 0; i < 3; i++) begin evStrobe = '1; @(negedge clk); end
    evStrobe = '0;
    rdChk(3'd4, 64'd5, "R2 out of range code");
  endtask

  task automatic t_filter();
    wr(3'd0, 64'd3);
    wr(3'd4, 64'd0);
    txnDevId = 16'h9999; txnPasid = 20'h12345; txnDomId = 16'h7777;
    pulse(3, 1);
    rdChk(3'd4, 64'd1, "R5 filters off pass");
    wr(3'd1, 64'h0000_000F_8000_1234);
    txnDevId = 16'h1239;
    pulse(3, 1);
    rdChk(3'd4, 64'd2, "R6 masked bits ignored");
    txnDevId = 16'h1334;
    pulse(3, 1);
    rdChk(3'd4, 64'd2, "R6 unmasked mismatch");
    txnDevId = 16'h1230;
    wr(3'd2, 64'h0000_0000_800A_BCDE);
    txnPasid = 20'hABCDE;
    pulse(3, 1);
    rdChk(3'd4, 64'd3, "R7 dev and pasid pass");
    txnPasid = 20'hABCDF;
    pulse(3, 1);
    rdChk(3'd4, 64'd3, "R7 pasid blocks");
    txnPasid = 20'hABCDE;
    wr(3'd3, 64'h0000_0000_8000_0055);
    txnDomId = 16'h0055;
    pulse(3, 1);
    rdChk(3'd4, 64'd4, "R7 all three pass");
    txnDomId = 16'h0056;
    pulse(3, 1);
    rdChk(3'd4, 64'd4, "R7 domain blocks");
    wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
    pulse(3, 1);
    rdChk(3'd4, 64'd5, "R5 filters cleared");
  endtask

  task automatic t_load();
    wr(3'd0, 64'd3);
    wr(3'd4, 64'hABCD_1234_5678_9ABC);
    rdChk(3'd4, 64'h0000_1234_5678_9ABC, "R9 upper bits dropped");
  endtask

  task automatic t_collide();
    wr(3'd0, 64'd3);
    evStrobe = '0; evStrobe[3] = 1'b1;
    wr(3'd4, 64'd100);
    evStrobe = '0;
    rdChk(3'd4, 64'd100, "R10 write wins");
    pulse(3, 1);
    rdChk(3'd4, 64'd101, "R10 counting resumes");
  endtask

  task automatic t_wrap();
    wr(3'd4, 64'h0000_FFFF_FFFF_FFFF);
    pulse(3, 1);
    rdChk(3'd4, 64'd0, "R11 wrap to zero");
  endtask

  task automatic t_srcTiming();
    wr(3'd0, 64'd3);
    wr(3'd4, 64'd0);
    evStrobe = '0; evStrobe[3] = 1'b1; evStrobe[4] = 1'b1;
    wr(3'd0, 64'd4);
    evStrobe = '0;
    rdChk(3'd4, 64'd1, "R12 old code in write cycle");
    pulse(4, 1);
    rdChk(3'd4, 64'd2, "R12 new code next cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_gate();
    t_count();
    t_filter();
    t_load();
    t_collide();
    t_wrap();
    t_srcTiming();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule